// File: doc/BRIEF.md
# Flash command sequence controller

This block is the command register of a parallel NOR flash model. It watches host write cycles and recognises multi-cycle unlock and command sequences. From them it starts embedded program operations, single-sector and multi-sector erases, and whole-chip erases. It also handles erase suspend and resume, and an unlock-bypass mode that shortens programming. It does not model the storage itself. Each embedded operation goes to an array controller as a one-cycle start pulse. The pulse carries an operation code, the latched address and the latched data, and the controller then waits for a done pulse.

A write is one clock cycle in which `host_ce` and `host_we` are both high. Only the low byte of the data is decoded as a command. The low 11 address bits are decoded as the unlock key. The top `SECT_BITS` address bits select a sector. Sector protection comes from a per-sector mask, and a temporary-unprotect input overrides that mask for as long as it is high. A synchronous reset aborts whatever is running and returns the block to read-array mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The sequence 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then one address/data write produces `arr_start` in the cycle after that fourth write. The pulse has `arr_op`=01 (program), `arr_addr` and `arr_data` equal to the fourth write, and lasts exactly one cycle.
- R2: The sequence 0xAA at 0x555, 0x55 at 0x2AA, 0x20 at 0x555 sets `bypass`. While `bypass` is set, 0xA0 at any address followed by an address/data write starts a program. 0x90 followed by 0x00 clears `bypass`. 0x90 followed by any other value leaves `bypass` set.
- R3: The sequence AA/555, 55/2AA, 80/555, AA/555, 55/2AA, then 0x30 at a sector address selects that sector for erase and opens a window of about `WIN_CYC` cycles. Each further 0x30 in the window adds a sector and restarts the window. When the window closes, the selected sectors are erased one at a time in ascending order. Each erase is an `arr_op`=10 start with `arr_addr` at the sector base.
- R4: The same five setup cycles followed by 0x10 at 0x555 erase every unprotected sector in ascending order. If every sector is protected, no start is issued.
- R5: A program or erase aimed at a sector whose `prot_mask` bit is set issues no start, unless `temp_unprot` is high.
- R6: A 0xB0 written during an erase lets the current sector finish, then holds further starts. `suspended` rises and `busy` falls. A 0x30 written while suspended resumes with the next pending sector.
- R7: While suspended, a full program sequence to a sector still pending erase issues no start, and one to any other sector starts normally. `rd_ok` is low for pending sectors and high for the others.
- R8: A wrong data value or address in any unlock or command cycle, including 0xF0, abandons the sequence with no start. A correct sequence is accepted immediately afterwards.
- R9: Writes made while a program or erase is busy are ignored, except 0xB0 during an erase.
- R10: `rst` ends any operation and clears `busy`, `suspended`, `bypass` and the pending-erase set. No further starts follow.
- R11: After the done pulse of the last operation, `busy` falls and a new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the hardware abort |
| host_ce | input | 1 | Host chip enable, active high |
| host_we | input | 1 | Host write enable, active high |
| host_addr | input | ADDR_W | Host word address for writes, and the read address for `rd_ok` |
| host_data | input | DATA_W | Host write data |
| prot_mask | input | 2**SECT_BITS | Per-sector protection flags |
| temp_unprot | input | 1 | Lifts all protection while high |
| arr_done | input | 1 | One-cycle completion pulse from the array controller |
| arr_start | output | 1 | One-cycle operation start |
| arr_op | output | 2 | 01 program, 10 sector erase |
| arr_addr | output | ADDR_W | Latched program address or sector base |
| arr_data | output | DATA_W | Latched program data |
| busy | output | 1 | An embedded operation or erase window is active |
| suspended | output | 1 | An erase is paused |
| bypass | output | 1 | Unlock-bypass mode is active |
| rd_ok | output | 1 | An array read at `host_addr` is allowed |

## Verification
A wrong decoder or sequence state shows at the ports in the cycle after the final write of a sequence. In that cycle `arr_start` is either present or missing, and its address and data either match the write or do not. A fault in the pending-erase set shows later: in the order and count of the erase starts, in `rd_ok` during a suspend, or in a program start that should not occur. A stuck suspend request or mode flag shows on `suspended` and `bypass`, and in whether the next sequence is accepted.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ, ST_U1, ST_U2, ST_E_SET, ST_E_U1, ST_E_U2,
        ST_PGM_AD, ST_PGM_RUN, ST_E_WIN, ST_E_RUN, ST_E_WAIT,
        ST_SUSP, ST_BYP_X
    } fsm_t;

    typedef enum logic [3:0] {
        C_OTHER, C_PGM, C_SETUP, C_BYP, C_SUSP, C_RES,
        C_CHIP, C_RST, C_BEXIT, C_ZERO
    } cmd_t;

    localparam logic [1:0] AOP_PGM = 2'b01;
    localparam logic [1:0] AOP_ERS = 2'b10;

    localparam logic [10:0] KEY_A = 11'h555;
    localparam logic [10:0] KEY_B = 11'h2AA;

    function automatic cmd_t classify(input logic [7:0] b);
        case (b)
            8'hA0:   return C_PGM;
            8'h80:   return C_SETUP;
            8'h20:   return C_BYP;
            8'hB0:   return C_SUSP;
            8'h30:   return C_RES;
            8'h10:   return C_CHIP;
            8'hF0:   return C_RST;
            8'h90:   return C_BEXIT;
            8'h00:   return C_ZERO;
            default: return C_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [10:0] addr_lo,
    input  logic [7:0]  cmd_byte,
    output logic        unl_a,
    output logic        unl_b,
    output logic        at_key,
    output cmd_t        cmd
);
    always_comb begin
        at_key = (addr_lo == KEY_A);
        unl_a  = at_key && (cmd_byte == 8'hAA);
        unl_b  = (addr_lo == KEY_B) && (cmd_byte == 8'h55);
        cmd    = classify(cmd_byte);
    end
endmodule

// File: rtl/flash_erase_queue.sv
module flash_erase_queue #(
    parameter int NUM_SECT = 8,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                add_en,
    input  logic [IDX_W-1:0]    add_idx,
    input  logic                load_en,
    input  logic [NUM_SECT-1:0] load_mask,
    input  logic                ret_en,
    input  logic [IDX_W-1:0]    ret_idx,
    output logic [NUM_SECT-1:0] pend,
    output logic                any,
    output logic [IDX_W-1:0]    next_idx
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend <= '0;
        end else begin
            if (load_en) pend <= load_mask;
            if (add_en)  pend[add_idx] <= 1'b1;
            if (ret_en)  pend[ret_idx] <= 1'b0;
        end
    end

    // lowest pending sector wins
    always_comb begin
        next_idx = '0;
        for (int i = NUM_SECT - 1; i >= 0; i--) begin
            if (pend[i]) next_idx = IDX_W'(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SECT_BITS = 3,
    parameter int DATA_W    = 16,
    parameter int WIN_CYC   = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        host_ce,
    input  logic                        host_we,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [DATA_W-1:0]           host_data,
    input  logic [(1<<SECT_BITS)-1:0]   prot_mask,
    input  logic                        temp_unprot,
    input  logic                        arr_done,
    output logic                        arr_start,
    output logic [1:0]                  arr_op,
    output logic [ADDR_W-1:0]           arr_addr,
    output logic [DATA_W-1:0]           arr_data,
    output logic                        busy,
    output logic                        suspended,
    output logic                        bypass,
    output logic                        rd_ok
);
    localparam int NUM_SECT = 1 << SECT_BITS;
    localparam int OFF_W    = ADDR_W - SECT_BITS;
    localparam int WIN_W    = $clog2(WIN_CYC + 1);

    fsm_t                 state, st_n, home;
    logic                 byp_q, byp_n, susp_q, susp_n, sreq_q, sreq_n;
    logic [WIN_W-1:0]     win_q, win_n;
    logic                 start_q, start_n;
    logic [1:0]           op_q, op_n;
    logic [ADDR_W-1:0]    aaddr_q, aaddr_n;
    logic [DATA_W-1:0]    adata_q, adata_n;

    logic                 wr, unl_a, unl_b, at_key;
    cmd_t                 cmd;
    logic [SECT_BITS-1:0] sect_w, sect_r, sect_run;
    logic [NUM_SECT-1:0]  prot_eff, pend_q;
    logic                 q_clr, q_add, q_load, q_ret, q_any;
    logic [SECT_BITS-1:0] q_next;

    assign wr       = host_ce && host_we;
    assign sect_w   = host_addr[ADDR_W-1 -: SECT_BITS];
    assign sect_r   = sect_w;
    assign sect_run = aaddr_q[ADDR_W-1 -: SECT_BITS];
    assign prot_eff = temp_unprot ? '0 : prot_mask;
    assign home     = susp_q ? ST_SUSP : ST_READ;

    flash_cmd_decode u_dec (
        .addr_lo  (host_addr[10:0]),
        .cmd_byte (host_data[7:0]),
        .unl_a    (unl_a),
        .unl_b    (unl_b),
        .at_key   (at_key),
        .cmd      (cmd)
    );

    flash_erase_queue #(.NUM_SECT(NUM_SECT), .IDX_W(SECT_BITS)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .clr       (q_clr),
        .add_en    (q_add),
        .add_idx   (sect_w),
        .load_en   (q_load),
        .load_mask (~prot_eff),
        .ret_en    (q_ret),
        .ret_idx   (sect_run),
        .pend      (pend_q),
        .any       (q_any),
        .next_idx  (q_next)
    );

    always_comb begin
        st_n = state;  byp_n = byp_q;  susp_n = susp_q;  sreq_n = sreq_q;
        win_n = win_q; start_n = 1'b0; op_n = op_q;
        aaddr_n = aaddr_q; adata_n = adata_q;
        q_clr = 1'b0; q_add = 1'b0; q_load = 1'b0; q_ret = 1'b0;
        case (state)
            ST_READ: if (wr) begin
                if (byp_q) begin
                    if (cmd == C_PGM)        st_n = ST_PGM_AD;
                    else if (cmd == C_BEXIT) st_n = ST_BYP_X;
                end else if (unl_a) begin
                    st_n = ST_U1;
                end
            end
            ST_SUSP: if (wr) begin
                if (cmd == C_RES) begin
                    susp_n = 1'b0;
                    st_n   = ST_E_RUN;
                end else if (unl_a) begin
                    st_n = ST_U1;
                end
            end
            ST_U1: if (wr) st_n = unl_b ? ST_U2 : home;
            ST_U2: if (wr) begin
                st_n = home;
                if (at_key) begin
                    if (cmd == C_PGM)                     st_n  = ST_PGM_AD;
                    else if (cmd == C_SETUP && !susp_q)   st_n  = ST_E_SET;
                    else if (cmd == C_BYP && !susp_q)     byp_n = 1'b1;
                end
            end
            ST_E_SET: if (wr) st_n = unl_a ? ST_E_U1 : ST_READ;
            ST_E_U1:  if (wr) st_n = unl_b ? ST_E_U2 : ST_READ;
            ST_E_U2: if (wr) begin
                st_n = ST_READ;
                if (cmd == C_CHIP && at_key) begin
                    q_load = 1'b1;
                    st_n   = ST_E_RUN;
                end else if (cmd == C_RES) begin
                    q_add = !prot_eff[sect_w];
                    win_n = WIN_W'(WIN_CYC);
                    st_n  = ST_E_WIN;
                end
            end
            ST_E_WIN: begin
                if (wr && cmd == C_RES) begin
                    q_add = !prot_eff[sect_w];
                    win_n = WIN_W'(WIN_CYC);
                end else if (wr) begin
                    q_clr = 1'b1;
                    st_n  = ST_READ;
                end else if (win_q == '0) begin
                    st_n = ST_E_RUN;
                end else begin
                    win_n = win_q - 1'b1;
                end
            end
            ST_E_RUN: begin
                if (!q_any) begin
                    st_n = ST_READ; susp_n = 1'b0; sreq_n = 1'b0;
                end else if (sreq_q || (wr && cmd == C_SUSP)) begin
                    sreq_n = 1'b0; susp_n = 1'b1; st_n = ST_SUSP;
                end else begin
                    start_n = 1'b1;
                    op_n    = AOP_ERS;
                    aaddr_n = {q_next, {OFF_W{1'b0}}};
                    st_n    = ST_E_WAIT;
                end
            end
            ST_E_WAIT: begin
                if (wr && cmd == C_SUSP) sreq_n = 1'b1;
                if (arr_done) begin
                    q_ret = 1'b1;
                    st_n  = ST_E_RUN;
                end
            end
            ST_PGM_AD: if (wr) begin
                st_n = home;
                if (!prot_eff[sect_w] && !(susp_q && pend_q[sect_w])) begin
                    start_n = 1'b1;
                    op_n    = AOP_PGM;
                    aaddr_n = host_addr;
                    adata_n = host_data;
                    st_n    = ST_PGM_RUN;
                end
            end
            ST_PGM_RUN: if (arr_done) st_n = home;
            ST_BYP_X: if (wr) begin
                st_n = ST_READ;
                if (cmd == C_ZERO) byp_n = 1'b0;
            end
            default: st_n = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_READ;
            byp_q   <= 1'b0;
            susp_q  <= 1'b0;
            sreq_q  <= 1'b0;
            win_q   <= '0;
            start_q <= 1'b0;
            op_q    <= '0;
            aaddr_q <= '0;
            adata_q <= '0;
        end else begin
            state   <= st_n;
            byp_q   <= byp_n;
            susp_q  <= susp_n;
            sreq_q  <= sreq_n;
            win_q   <= win_n;
            start_q <= start_n;
            op_q    <= op_n;
            aaddr_q <= aaddr_n;
            adata_q <= adata_n;
        end
    end

    always_comb begin
        busy = (state == ST_PGM_RUN) || (state == ST_E_WIN) ||
               (state == ST_E_RUN)   || (state == ST_E_WAIT);
        rd_ok = !busy && !(susp_q && pend_q[sect_r]);
    end

    assign arr_start = start_q;
    assign arr_op    = op_q;
    assign arr_addr  = aaddr_q;
    assign arr_data  = adata_q;
    assign suspended = susp_q;
    assign bypass    = byp_q;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
    parameter int ADDR_W    = 16,
    parameter int SECT_BITS = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      arr_start,
    input logic [1:0]                arr_op,
    input logic [ADDR_W-1:0]         arr_addr,
    input logic [(1<<SECT_BITS)-1:0] prot_mask,
    input logic                      temp_unprot,
    input logic                      busy,
    input logic                      suspended,
    input logic                      bypass,
    input logic [(1<<SECT_BITS)-1:0] pend
);
    logic [SECT_BITS-1:0] s_idx;
    assign s_idx = arr_addr[ADDR_W-1 -: SECT_BITS];

    // R1: a start lasts one cycle
    p_start_single_r1: assert property (@(posedge clk) disable iff (rst)
        arr_start |=> !arr_start);

    // R5: a program start never targets a sector protected when it was latched
    p_prot_respected_r5: assert property (@(posedge clk) disable iff (rst)
        (arr_start && arr_op == 2'b01) |-> !($past(prot_mask[s_idx]) && !$past(temp_unprot)));

    // R3: every erase start targets a pending sector
    p_ers_pending_r3: assert property (@(posedge clk) disable iff (rst)
        (arr_start && arr_op == 2'b10) |-> pend[s_idx]);

    // R7: a program during suspend never hits a sector awaiting erase
    p_susp_other_r7: assert property (@(posedge clk) disable iff (rst)
        (arr_start && arr_op == 2'b01 && suspended) |-> !pend[s_idx]);

    // R6: paused and idle means no start
    p_susp_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (suspended && !busy) |-> !arr_start);

    // R10: reset leaves the controller quiet
    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (!busy && !suspended && !bypass && !arr_start));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .arr_start   (arr_start),
    .arr_op      (arr_op),
    .arr_addr    (arr_addr),
    .prot_mask   (prot_mask),
    .temp_unprot (temp_unprot),
    .busy        (busy),
    .suspended   (suspended),
    .bypass      (bypass),
    .pend        (pend_q)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    localparam int ADDR_W = 16, SECT_BITS = 3, DATA_W = 16, WIN_CYC = 8;
    localparam int NS = 1 << SECT_BITS;
    localparam int LAT = 12;

    logic clk = 1'b0, rst = 1'b1;
    logic host_ce = 1'b0, host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_data = '0;
    logic [NS-1:0] prot_mask = '0;
    logic temp_unprot = 1'b0, arr_done = 1'b0;
    logic arr_start, busy, suspended, bypass, rd_ok;
    logic [1:0] arr_op;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_data;

    int n_chk = 0, n_err = 0, n_log = 0, cnt = 0;
    logic [1:0]        log_op   [256];
    logic [ADDR_W-1:0] log_addr [256];
    logic [DATA_W-1:0] log_data [256];
    int base, k;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .DATA_W(DATA_W), .WIN_CYC(WIN_CYC)) dut (
        .clk(clk), .rst(rst), .host_ce(host_ce), .host_we(host_we),
        .host_addr(host_addr), .host_data(host_data), .prot_mask(prot_mask),
        .temp_unprot(temp_unprot), .arr_done(arr_done), .arr_start(arr_start),
        .arr_op(arr_op), .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy),
        .suspended(suspended), .bypass(bypass), .rd_ok(rd_ok));

    // behavioural array stub: logs starts, answers after LAT cycles
    always @(posedge clk) begin
        arr_done <= 1'b0;
        if (rst) begin
            cnt <= 0;
        end else if (arr_start) begin
            cnt <= LAT;
            if (n_log < 256) begin
                log_op[n_log]   <= arr_op;
                log_addr[n_log] <= arr_addr;
                log_data[n_log] <= arr_data;
            end
            n_log <= n_log + 1;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) arr_done <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        host_ce = 1'b1; host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_ce = 1'b0; host_we = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0055);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        for (int g = 0; g < 5000 && busy; g++) @(negedge clk);
    endtask

    task automatic erase_setup();
        unlock();
        wr(16'h0555, 16'h0080);
        unlock();
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        chk(!busy && !suspended && !bypass && !arr_start && rd_ok, "R10 reset state",
            {busy, suspended, bypass, arr_start, rd_ok}, 5'b00001);

        // R1 / R5 / R11: program sweep over sectors and protection modes
        for (int s = 0; s < NS; s++) begin
            for (int m = 0; m < 3; m++) begin
                logic [ADDR_W-1:0] a;
                logic [DATA_W-1:0] d;
                bit exp_go;
                a = ADDR_W'((s << 13) | 16'h0123 | (m << 4));
                d = DATA_W'(16'h3C00 + s * 3 + m);
                prot_mask = (m == 0) ? '0 : NS'(1 << s);
                temp_unprot = (m == 2);
                exp_go = (m != 1);
                base = n_log;
                unlock();
                wr(16'h0555, 16'h00A0);
                wr(a, d);
                chk(arr_start == exp_go, "R1/R5 start after fourth write", arr_start, exp_go);
                if (exp_go) chk(arr_op == 2'b01 && arr_addr == a && arr_data == d,
                                "R1 latched op/addr/data", {arr_op, arr_addr, arr_data}, {2'b01, a, d});
                wait_idle();
                chk(n_log - base == int'(exp_go), "R5 start count", n_log - base, exp_go);
                chk(!busy, "R11 idle after done", busy, 0);
            end
        end
        prot_mask = '0; temp_unprot = 1'b0;

        // R8: corrupt each unlock/command cycle by data or address
        for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 2; v++) begin
                logic [ADDR_W-1:0] aa [3];
                logic [DATA_W-1:0] dd [3];
                aa[0] = 16'h0555; dd[0] = 16'h00AA;
                aa[1] = 16'h02AA; dd[1] = 16'h0055;
                aa[2] = 16'h0555; dd[2] = 16'h00A0;
                if (v == 0) dd[p] = dd[p] ^ 16'h0001;
                else        aa[p] = aa[p] ^ 16'h0003;
                base = n_log;
                for (int c = 0; c < 3; c++) wr(aa[c], dd[c]);
                wr(16'h2222, 16'h1234);
                repeat (4) @(negedge clk);
                chk(n_log == base && !busy, "R8 corrupted sequence ignored", n_log - base, 0);
            end
        end
        base = n_log;
        unlock();
        wr(16'h7777, 16'h00F0);
        wr(16'h0555, 16'h00A0);
        wr(16'h2222, 16'h1234);
        repeat (4) @(negedge clk);
        chk(n_log == base, "R8 F0 abandons", n_log - base, 0);
        unlock();
        wr(16'h0555, 16'h00A0);
        wr(16'h2468, 16'hBEEF);
        chk(arr_start && arr_addr == 16'h2468, "R8 accepted after abandon", arr_addr, 16'h2468);
        wait_idle();

        // R2: unlock bypass
        unlock();
        wr(16'h0555, 16'h0020);
        chk(bypass, "R2 bypass entered", bypass, 1);
        for (int i = 0; i < 4; i++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'(16'h6000 + i * 16'h0911);
            wr(ADDR_W'(i), 16'h00A0);
            wr(a, DATA_W'(16'h5A00 + i));
            chk(arr_start && arr_op == 2'b01 && arr_addr == a, "R2 two-cycle program",
                arr_addr, a);
            wait_idle();
        end
        chk(bypass, "R2 bypass kept", bypass, 1);
        wr(16'h0000, 16'h0090);
        wr(16'h0000, 16'h0005);
        chk(bypass, "R2 bad exit keeps bypass", bypass, 1);
        wr(16'h0000, 16'h0090);
        wr(16'h0000, 16'h0000);
        chk(!bypass, "R2 bypass exited", bypass, 0);
        base = n_log;
        wr(16'h0555, 16'h00A0);
        wr(16'h4444, 16'h1111);
        repeat (3) @(negedge clk);
        chk(n_log == base, "R2 two-cycle rejected outside bypass", n_log - base, 0);

        // R3: multi-sector erase, ascending order, protection respected
        for (int m = 0; m < 2; m++) begin
            prot_mask = (m == 1) ? NS'(8'h04) : '0;
            base = n_log;
            erase_setup();
            wr(16'hA000, 16'h0030);
            wr(16'h4000, 16'h0030);
            wait_idle();
            k = (m == 1) ? 1 : 2;
            chk(n_log - base == k, "R3/R5 erase count", n_log - base, k);
            if (m == 0) begin
                chk(log_op[base] == 2'b10 && log_addr[base] == 16'h4000, "R3 first erase sector 2",
                    log_addr[base], 16'h4000);
                chk(log_addr[base+1] == 16'hA000, "R3 second erase sector 5", log_addr[base+1], 16'hA000);
            end else begin
                chk(log_addr[base] == 16'hA000, "R5 protected sector skipped", log_addr[base], 16'hA000);
            end
        end

        // R4: chip erase over protection masks
        for (int t = 0; t < 4; t++) begin
            logic [NS-1:0] mk;
            mk = (t == 0) ? 8'h00 : (t == 1) ? 8'hA5 : (t == 2) ? 8'hFF : 8'h7E;
            prot_mask = mk;
            base = n_log;
            erase_setup();
            wr(16'h0555, 16'h0010);
            wait_idle();
            k = 0;
            for (int s = 0; s < NS; s++) begin
                if (!mk[s]) begin
                    chk(log_op[base+k] == 2'b10 && log_addr[base+k] == ADDR_W'(s << 13),
                        "R4 chip erase order", log_addr[base+k], s << 13);
                    k++;
                end
            end
            chk(n_log - base == k && !busy, "R4 chip erase count", n_log - base, k);
        end
        prot_mask = '0;

        // R9: writes during a busy program are ignored
        base = n_log;
        unlock();
        wr(16'h0555, 16'h00A0);
        wr(16'h3000, 16'h0001);
        unlock();
        wr(16'h0555, 16'h00A0);
        wr(16'h5000, 16'h0002);
        wait_idle();
        wr(16'h5000, 16'h0002);
        repeat (3) @(negedge clk);
        chk(n_log - base == 1, "R9 writes during busy ignored", n_log - base, 1);

        // R6 / R7: suspend, program elsewhere, resume
        base = n_log;
        erase_setup();
        wr(16'h0555, 16'h0010);
        for (int g = 0; g < 100 && n_log == base; g++) @(negedge clk);
        wr(16'h1234, 16'h00B0);
        wait_idle();
        chk(suspended && !busy, "R6 suspended", {suspended, busy}, 2'b10);
        repeat (40) @(negedge clk);
        chk(n_log - base == 1, "R6 no starts while suspended", n_log - base, 1);
        host_addr = 16'h6000; #1;
        chk(!rd_ok, "R7 pending sector unreadable", rd_ok, 0);
        host_addr = 16'h0100; #1;
        chk(rd_ok, "R7 erased sector readable", rd_ok, 1);
        unlock();
        wr(16'h0555, 16'h00A0);
        wr(16'h6010, 16'h0077);
        chk(!arr_start, "R7 program to pending sector refused", arr_start, 0);
        unlock();
        wr(16'h0555, 16'h00A0);
        wr(16'h0100, 16'h0066);
        chk(arr_start && arr_addr == 16'h0100, "R7 program to other sector", arr_addr, 16'h0100);
        wait_idle();
        chk(suspended, "R7 back in suspend", suspended, 1);
        wr(16'h0000, 16'h0030);
        wait_idle();
        chk(!suspended && n_log - base == 9, "R6 resume completes", n_log - base, 9);
        for (int s = 1; s < NS; s++)
            chk(log_addr[base+1+s] == ADDR_W'(s << 13), "R6 resumed order",
                log_addr[base+1+s], s << 13);

        // R10: reset aborts an erase and clears bypass
        base = n_log;
        erase_setup();
        wr(16'h0555, 16'h0010);
        for (int g = 0; g < 100 && n_log == base; g++) @(negedge clk);
        do_reset();
        chk(!busy && !suspended, "R10 abort erase", busy, 0);
        repeat (60) @(negedge clk);
        chk(n_log - base == 1, "R10 no starts after reset", n_log - base, 1);
        unlock();
        wr(16'h0555, 16'h0020);
        do_reset();
        chk(!bypass, "R10 bypass cleared", bypass, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule